// File: doc/BRIEF.md
# Timed Receive Stream Command Queue

This block gates a stream of receive samples under the control of queued stream commands. A host writes each command through a small register port. The command is spread over three registers: a control word, the upper 32 bits of the start time and the lower 32 bits of the start time. The command enters a small command FIFO only when the lower start-time register is written. The first two writes only stage their values.

A free-running 64-bit timebase is compared with the start time of the command at the head of the queue. An immediate command opens the gate at once. A timed command keeps the gate closed until the timebase reaches its start time. Once the gate is open, exactly the commanded number of valid samples pass. A command flagged for chaining hands over to the next queued command on the very next sample. A missed start time, a chain that finds the queue empty, and a push into a full queue each raise their own sticky status flag. One write of any value to a clear register drops all three flags.

Top module: `rx_timed_gate`

## Requirements
- R1: Register address 0 holds the control word, with bit 31 as the immediate flag, bit 30 as the chain flag and bits 29:0 as the sample count. Address 1 holds start-time bits 63:32. Writing address 2 with start-time bits 31:0 commits the triplet as one command. Writes to addresses 0 and 1 alone start nothing.
- R2: An immediate command begins passing samples without regard to the timebase.
- R3: A timed command passes no sample until `timeNow` is equal to or later than its start time.
- R4: A command without the chain flag passes exactly its count of valid samples. Later samples are dropped.
- R5: A timed command whose start time is already earlier than `timeNow` when it reaches the head of the queue is discarded without passing any sample, and `lateErr` is set.
- R6: When a chained command finishes and another command is queued, that command takes over on the next sample with no gap, ignoring its start time.
- R7: When a chained command finishes and the queue is empty, `chainErr` is set and streaming stops.
- R8: A commit while the FIFO already holds `CMD_DEPTH` commands is ignored and sets `queueOverflow`.
- R9: A write of any value to address 3 clears `lateErr`, `chainErr` and `queueOverflow`.
- R10: After reset, all status flags and `sampleOutValid` are low and the block is not streaming.
- R11: A passed sample appears on `sampleOut` one cycle after it is presented, with its value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regData | input | 32 | Register write data |
| timeNow | input | 64 | Current timebase value |
| sampleIn | input | DATA_W | Incoming sample |
| sampleInValid | input | 1 | Incoming sample is valid |
| sampleOut | output | DATA_W | Gated sample |
| sampleOutValid | output | 1 | Gated sample is valid |
| streaming | output | 1 | The gate is open for the current command |
| lateErr | output | 1 | Sticky flag: a timed command was discarded as late |
| chainErr | output | 1 | Sticky flag: a chain found the queue empty |
| queueOverflow | output | 1 | Sticky flag: a commit hit a full queue |

## Verification
A table of single commands exercises the gate with several patterns: immediate starts with short, single-sample and long counts; timed starts at near and far offsets; and a start time already in the past. Together these separate an exact-count cut-off from a gate that overruns, a time wait from an early opening, and a late discard from a silent start. Directed sequences then cover the rest. A control word staged without a commit must pass nothing. A chained pair under a continuous input stream must produce consecutive sample values, which exposes any bubble at the handover. A lone chained command must raise the chain error. A timed head holding back a full queue must show, by the total number of passed samples, that the extra commit was dropped.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_THI   = 2'd1;
  localparam logic [1:0] ADDR_TLO   = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;

  localparam int CNT_W  = 30;
  localparam int TIME_W = 64;

  // One queued stream command
  typedef struct packed {
    logic              immediate;
    logic              chain;
    logic [CNT_W-1:0]  count;
    logic [TIME_W-1:0] startTime;
  } rxq_cmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pop;
    logic pass;
  } rxq_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } rxq_state_e;

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CMD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regData,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleInValid,
  input  rxq_strobe_t       strobe,
  output rxq_cmd_t          headCmd,
  output logic              queueEmpty,
  output logic              queueOverflow,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleOutValid
);

  localparam int PTR_W = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;
  localparam int OCC_W = $clog2(CMD_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(CMD_DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(CMD_DEPTH);

  logic [31:0]      stageCtrl;
  logic [31:0]      stageHi;
  rxq_cmd_t         cmdMem [CMD_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [OCC_W-1:0] occ;
  logic             queueFull;
  logic             commitReq;
  logic             doPush;
  logic             doPop;
  logic             clearReq;
  rxq_cmd_t         newCmd;

  assign queueFull  = (occ == FULL_OCC);
  assign queueEmpty = (occ == '0);
  assign commitReq  = regWe && (regAddr == ADDR_TLO);
  assign clearReq   = regWe && (regAddr == ADDR_CLEAR);
  assign doPush     = commitReq && !queueFull;
  assign doPop      = strobe.pop && !queueEmpty;

  always_comb begin
    newCmd.immediate = stageCtrl[31];
    newCmd.chain     = stageCtrl[30];
    newCmd.count     = stageCtrl[CNT_W-1:0];
    newCmd.startTime = {stageHi, regData};
  end

  assign headCmd = cmdMem[rdPtr];

  // staging registers for the first two words of a command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageCtrl <= '0;
      stageHi   <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_CTRL) stageCtrl <= regData;
      if (regAddr == ADDR_THI)  stageHi   <= regData;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) cmdMem[wrPtr] <= newCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      queueOverflow <= 1'b0;
    else if (clearReq)              queueOverflow <= 1'b0;
    else if (commitReq && queueFull) queueOverflow <= 1'b1;
  end

  // sample gate, one register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOutValid <= 1'b0;
      sampleOut      <= '0;
    end else begin
      sampleOutValid <= sampleInValid && strobe.pass;
      sampleOut      <= sampleIn;
    end
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [TIME_W-1:0] timeNow,
  input  rxq_cmd_t          headCmd,
  input  logic              queueEmpty,
  input  logic              sampleInValid,
  output rxq_strobe_t       strobe,
  output logic              streaming,
  output logic              lateErr,
  output logic              chainErr
);

  rxq_state_e        state, stateNext;
  logic [CNT_W-1:0]  remaining, remainingNext;
  logic              chainQ, chainNext;
  logic [TIME_W-1:0] startQ, startNext;
  logic              lateSet;
  logic              chainSet;
  logic              popReq;
  logic              lastBeat;
  logic              clearReq;

  assign clearReq  = regWe && (regAddr == ADDR_CLEAR);
  assign streaming = (state == ST_RUN);

  always_comb begin
    stateNext     = state;
    remainingNext = remaining;
    chainNext     = chainQ;
    startNext     = startQ;
    lateSet       = 1'b0;
    chainSet      = 1'b0;
    popReq        = 1'b0;
    lastBeat      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!queueEmpty) begin
          popReq = 1'b1;
          if (!headCmd.immediate && (timeNow > headCmd.startTime)) begin
            lateSet = 1'b1;
          end else begin
            remainingNext = headCmd.count;
            chainNext     = headCmd.chain;
            startNext     = headCmd.startTime;
            stateNext     = headCmd.immediate ? ST_RUN : ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (timeNow >= startQ) stateNext = ST_RUN;
      end
      ST_RUN: begin
        lastBeat = (remaining == '0) || (sampleInValid && (remaining == CNT_W'(1)));
        if (sampleInValid && (remaining != '0)) remainingNext = remaining - 1'b1;
        if (lastBeat) begin
          if (chainQ) begin
            if (!queueEmpty) begin
              popReq        = 1'b1;
              remainingNext = headCmd.count;
              chainNext     = headCmd.chain;
            end else begin
              chainSet  = 1'b1;
              stateNext = ST_IDLE;
            end
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.pop  = popReq;
    strobe.pass = (state == ST_RUN) && (remaining != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      chainQ    <= 1'b0;
      startQ    <= '0;
    end else begin
      state     <= stateNext;
      remaining <= remainingNext;
      chainQ    <= chainNext;
      startQ    <= startNext;
    end
  end

  // sticky flags, a clear write takes precedence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lateErr  <= 1'b0;
      chainErr <= 1'b0;
    end else if (clearReq) begin
      lateErr  <= 1'b0;
      chainErr <= 1'b0;
    end else begin
      if (lateSet)  lateErr  <= 1'b1;
      if (chainSet) chainErr <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_timed_gate.sv
module rx_timed_gate
  import rxq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CMD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regData,
  input  logic [63:0]       timeNow,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleInValid,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleOutValid,
  output logic              streaming,
  output logic              lateErr,
  output logic              chainErr,
  output logic              queueOverflow
);

  rxq_strobe_t strobe;
  rxq_cmd_t    headCmd;
  logic        queueEmpty;

  rxq_datapath #(
    .DATA_W    (DATA_W),
    .CMD_DEPTH (CMD_DEPTH)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .regWe          (regWe),
    .regAddr        (regAddr),
    .regData        (regData),
    .sampleIn       (sampleIn),
    .sampleInValid  (sampleInValid),
    .strobe         (strobe),
    .headCmd        (headCmd),
    .queueEmpty     (queueEmpty),
    .queueOverflow  (queueOverflow),
    .sampleOut      (sampleOut),
    .sampleOutValid (sampleOutValid)
  );

  rxq_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regWe         (regWe),
    .regAddr       (regAddr),
    .timeNow       (timeNow),
    .headCmd       (headCmd),
    .queueEmpty    (queueEmpty),
    .sampleInValid (sampleInValid),
    .strobe        (strobe),
    .streaming     (streaming),
    .lateErr       (lateErr),
    .chainErr      (chainErr)
  );

endmodule

// File: rtl/rx_timed_gate_chk.sv
module rx_timed_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] sampleIn,
  input logic              sampleInValid,
  input logic [DATA_W-1:0] sampleOut,
  input logic              sampleOutValid,
  input logic              streaming,
  input logic              lateErr,
  input logic              chainErr,
  input logic              queueOverflow
);

  // R11
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleOutValid |-> ($past(sampleInValid) && (sampleOut == $past(sampleIn))));

  // R3
  pass_only_streaming_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleOutValid |-> $past(streaming));

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd3) |=> (!lateErr && !chainErr && !queueOverflow));

  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(queueOverflow) |-> $past(regWe && regAddr == 2'd2));

  // R5
  late_not_streaming_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lateErr) |-> !$past(streaming));

  // R7
  chain_err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainErr) |-> !streaming);

endmodule

bind rx_timed_gate rx_timed_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .regWe          (regWe),
  .regAddr        (regAddr),
  .sampleIn       (sampleIn),
  .sampleInValid  (sampleInValid),
  .sampleOut      (sampleOut),
  .sampleOutValid (sampleOutValid),
  .streaming      (streaming),
  .lateErr        (lateErr),
  .chainErr       (chainErr),
  .queueOverflow  (queueOverflow)
);

// File: tb/rx_timed_gate_tb.sv
`timescale 1ns/1ps
module rx_timed_gate_tb;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [1:0]        regAddr = '0;
  logic [31:0]       regData = '0;
  logic [63:0]       timeNow = 64'd1000;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              sampleInValid = 1'b0;
  logic [DATA_W-1:0] sampleOut;
  logic              sampleOutValid;
  logic              streaming;
  logic              lateErr;
  logic              chainErr;
  logic              queueOverflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor state
  int          passCnt = 0;
  int          dataBad = 0;
  logic [31:0] firstVal, lastVal;
  logic [63:0] firstTime;
  logic [31:0] seq = 32'd1;

  // stimulus / expected table: immediate, count, time offset, expected passed, expected late
  localparam int NV = 6;
  localparam int vImm  [NV] = '{1, 1, 0, 0, 1, 0};
  localparam int vCnt  [NV] = '{5, 1, 8, 4, 25, 3};
  localparam int vOff  [NV] = '{0, 0, 10, -5, 0, 20};
  localparam int vPass [NV] = '{5, 1, 8, 0, 25, 3};
  localparam int vLate [NV] = '{0, 0, 0, 1, 0, 0};

  rx_timed_gate #(.DATA_W(DATA_W), .CMD_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .timeNow(timeNow), .sampleIn(sampleIn), .sampleInValid(sampleInValid),
    .sampleOut(sampleOut), .sampleOutValid(sampleOutValid), .streaming(streaming),
    .lateErr(lateErr), .chainErr(chainErr), .queueOverflow(queueOverflow)
  );

  always #4 clk = ~clk;

  always @(posedge clk) timeNow <= timeNow + 64'd1;

  always @(posedge clk) begin
    #2;
    if (rstN && sampleOutValid) begin
      if (passCnt == 0) begin
        firstVal  = sampleOut;
        firstTime = timeNow;
      end
      lastVal = sampleOut;
      passCnt++;
      // R11: the input that produced this output is still held
      if (sampleOut != sampleIn) dataBad++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pushCmd(input bit imm, input bit chn, input int cnt, input logic [63:0] st);
    wrReg(2'd0, {imm, chn, 30'(cnt)});
    wrReg(2'd1, st[63:32]);
    wrReg(2'd2, st[31:0]);
  endtask

  task automatic drive(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleInValid = 1'b1;
      sampleIn = seq;
      seq = seq + 1;
    end
    @(negedge clk);
    sampleInValid = 1'b0;
  endtask

  task automatic clearMon();
    @(negedge clk);
    passCnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 outValid", sampleOutValid, 0);
    check("R10 streaming", streaming, 0);
    check("R10 flags", {lateErr, chainErr, queueOverflow}, 0);

    // table of single commands
    for (int v = 0; v < NV; v++) begin
      logic [63:0] st;
      clearMon();
      st = timeNow + 64'(vOff[v]);
      pushCmd(vImm[v] != 0, 1'b0, vCnt[v], st);
      idle(2);
      drive(30);
      idle(5);
      if (vImm[v] != 0) check("R2 R4 immediate count", passCnt, vPass[v]);
      else if (vLate[v] != 0) check("R5 late passes none", passCnt, 0);
      else check("R3 R4 timed count", passCnt, vPass[v]);
      if (vImm[v] == 0 && vPass[v] > 0)
        check("R3 no early start", (firstTime >= st) ? 1 : 0, 1);
      check("R5 late flag", lateErr, vLate[v]);
      check("R4 gate closed", streaming, 0);
      wrReg(2'd3, 32'h0);
    end
    check("R11 data and latency", dataBad, 0);

    // R1: staged words without commit start nothing
    clearMon();
    wrReg(2'd0, {1'b1, 1'b0, 30'd3});
    wrReg(2'd1, 32'd0);
    drive(10);
    idle(3);
    check("R1 no commit no pass", passCnt, 0);
    wrReg(2'd2, 32'd0);
    idle(2);
    drive(10);
    idle(3);
    check("R1 commit passes count", passCnt, 3);

    // R6: chained pair, second start time far in future is ignored
    clearMon();
    pushCmd(1'b1, 1'b1, 4, 64'd0);
    pushCmd(1'b0, 1'b0, 3, timeNow + 64'd100000);
    idle(2);
    drive(20);
    idle(4);
    check("R6 chained total", passCnt, 7);
    check("R6 no gap", lastVal - firstVal, 6);
    check("R6 no chain error", chainErr, 0);

    // R7: lone chained command runs dry
    clearMon();
    pushCmd(1'b1, 1'b1, 3, 64'd0);
    idle(2);
    drive(10);
    idle(3);
    check("R7 count before stop", passCnt, 3);
    check("R7 chain error", chainErr, 1);
    check("R7 stopped", streaming, 0);

    // R9: arbitrary clear value
    wrReg(2'd3, 32'h1234_5678);
    @(negedge clk);
    check("R9 flags cleared", {lateErr, chainErr}, 0);

    // R8: full queue behind a timed head
    clearMon();
    pushCmd(1'b0, 1'b0, 1, timeNow + 64'd300);
    idle(2);
    for (int k = 0; k <= DEPTH; k++) pushCmd(1'b1, 1'b0, 1, 64'd0);
    @(negedge clk);
    check("R8 overflow flag", queueOverflow, 1);
    drive(400);
    idle(4);
    check("R8 extra commit ignored", passCnt, DEPTH + 1);
    wrReg(2'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 overflow cleared", queueOverflow, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule